// File: doc/BRIEF.md
# Auto-Commit Packet Capture FIFO

This block sits between a sample sequencer and a packet consumer. The sequencer
pushes one 8-bit sample per strobe. The FIFO places the samples into a small set
of equally sized buffers. When the buffer being filled reaches a programmed byte
count, it is handed to the read side without any further command. The read side
offers each committed packet as a stream with valid, data, last and ready.

Buffers are filled and drained in a fixed rotating order. The full flag
reports that no buffer is free, and the sequencer uses it to stop sampling. A
sample that arrives anyway is discarded and a sticky overflow flag is set. A
synchronous flush input empties every buffer in a single cycle. The
active-low asynchronous reset does the same.

Top module: `auto_commit_pkt_fifo`

## Requirements
- R1: After rst_ni is low, or after a clock edge with flush_i high, rd_valid_o, full_o and overflow_o are 0 and every buffer is empty, so the next packet starts at fill count zero in buffer 0.
- R2: The commit length is the 16-bit value {len_hi_i, len_lo_i}. A value of 0, or a value above BUF_DEPTH, is treated as BUF_DEPTH.
- R3: An accepted write that brings the fill count of the current buffer to the commit length commits that buffer. rd_valid_o is 1 from the cycle after that clock edge.
- R4: Buffers are filled and drained in strict round-robin order. Bytes leave on rd_data_o in the order they were accepted.
- R5: rd_last_o is 1 exactly while the final byte of the head packet is presented with rd_valid_o high.
- R6: full_o is 1 exactly when all NUM_BUF buffers hold committed packets not yet fully read. It falls in the cycle after the last byte of a packet is taken.
- R7: A write with full_o high is dropped and does not appear in any later packet. It sets overflow_o, which stays 1 until reset or flush.
- R8: While rd_valid_o is 1 and rd_ready_i is 0, rd_valid_o, rd_data_o and rd_last_o hold their values.
- R9: The commit length is compared on every write. If the length is lowered in the middle of a packet, the next accepted write commits that packet once the fill count is at or above the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous flush of all buffers and the overflow flag |
| len_hi_i | input | 8 | Commit length, upper byte |
| len_lo_i | input | 8 | Commit length, lower byte |
| wr_en_i | input | 1 | Sample strobe |
| wr_data_i | input | DATA_W | Sample byte |
| full_o | output | 1 | No free buffer remains |
| overflow_o | output | 1 | Sticky: a write was dropped |
| rd_valid_o | output | 1 | Head packet byte available |
| rd_data_o | output | DATA_W | Head packet byte |
| rd_last_o | output | 1 | Final byte of the head packet |
| rd_ready_i | input | 1 | Consumer takes the byte |

## Verification
The bench builds the block with NUM_BUF=4 and BUF_DEPTH=16. With these values all four buffers fill after at most 64 samples, so full, the drop of writes and overflow are reached many times in a short run. The small depth also lets a programmed length of 0x0200 exceed the buffer and exercise the clamp, and lets random lengths from 1 to 20 cover short packets, full-depth packets and clamped lengths. Lengths that change in the middle of a packet cover the re-evaluation on each write.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
  localparam int LEN_W = 16;

  // zero or oversize request maps to the full buffer depth
  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] req, input int depth);
    if (req == '0 || int'(req) > depth) return LEN_W'(depth);
    return req;
  endfunction
endpackage

// File: rtl/pfifo_len_cfg.sv
module pfifo_len_cfg
  import pfifo_pkg::*;
#(
  parameter int BUF_DEPTH = 512
) (
  input  logic [7:0]       len_hi_i,
  input  logic [7:0]       len_lo_i,
  output logic [LEN_W-1:0] eff_len_o
);
  always_comb eff_len_o = clamp_len({len_hi_i, len_lo_i}, BUF_DEPTH);
endmodule

// File: rtl/pfifo_bank.sv
module pfifo_bank #(
  parameter int NUM_BUF   = 4,
  parameter int BUF_DEPTH = 512,
  parameter int DATA_W    = 8,
  localparam int BUF_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int PTR_W    = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [BUF_W-1:0]  wr_buf_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BUF_W-1:0]  rd_buf_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] rd_word [NUM_BUF];

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    logic [DATA_W-1:0] mem_q [BUF_DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wr_buf_i == BUF_W'(g)) mem_q[wr_ptr_i] <= wr_data_i;
    end

    always_comb rd_word[g] = mem_q[rd_ptr_i];
  end

  always_comb rd_data_o = rd_word[rd_buf_i];
endmodule

// File: rtl/pfifo_wr_ctrl.sv
module pfifo_wr_ctrl
  import pfifo_pkg::*;
#(
  parameter int NUM_BUF   = 4,
  parameter int BUF_DEPTH = 512,
  localparam int BUF_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int PTR_W    = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_en_i,
  input  logic             full_i,
  input  logic [LEN_W-1:0] eff_len_i,
  output logic             we_o,
  output logic [BUF_W-1:0] wr_buf_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             commit_o,
  output logic [CNT_W-1:0] commit_len_o,
  output logic             overflow_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [BUF_W-1:0] buf_q, buf_nxt;
  logic             ovf_q;
  logic             accept;
  logic [LEN_W-1:0] cnt_inc;

  always_comb begin
    accept       = wr_en_i & ~full_i;
    cnt_inc      = LEN_W'(cnt_q) + LEN_W'(1);
    commit_o     = accept & (cnt_inc >= eff_len_i);
    commit_len_o = cnt_q + CNT_W'(1);
    buf_nxt      = (buf_q == BUF_W'(NUM_BUF - 1)) ? '0 : buf_q + BUF_W'(1);
    we_o         = accept;
    wr_buf_o     = buf_q;
    wr_ptr_o     = cnt_q[PTR_W-1:0];
    overflow_o   = ovf_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      buf_q <= '0;
      ovf_q <= 1'b0;
    end else if (flush_i) begin
      cnt_q <= '0;
      buf_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_en_i && full_i) ovf_q <= 1'b1;
      if (commit_o) begin
        cnt_q <= '0;
        buf_q <= buf_nxt;
      end else if (accept) begin
        cnt_q <= commit_len_o;
      end
    end
  end
endmodule

// File: rtl/pfifo_rd_ctrl.sv
module pfifo_rd_ctrl #(
  parameter int NUM_BUF   = 4,
  parameter int BUF_DEPTH = 512,
  localparam int BUF_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int PTR_W    = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             avail_i,
  input  logic             rd_ready_i,
  input  logic [CNT_W-1:0] head_len_i,
  output logic [BUF_W-1:0] rd_buf_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             last_o,
  output logic             release_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [BUF_W-1:0] buf_q, buf_nxt;
  logic             at_end, fire;

  always_comb begin
    at_end    = (CNT_W'(ptr_q) + CNT_W'(1)) == head_len_i;
    fire      = avail_i & rd_ready_i;
    release_o = fire & at_end;
    last_o    = avail_i & at_end;
    buf_nxt   = (buf_q == BUF_W'(NUM_BUF - 1)) ? '0 : buf_q + BUF_W'(1);
    rd_buf_o  = buf_q;
    rd_ptr_o  = ptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      buf_q <= '0;
    end else if (flush_i) begin
      ptr_q <= '0;
      buf_q <= '0;
    end else if (fire) begin
      if (at_end) begin
        ptr_q <= '0;
        buf_q <= buf_nxt;
      end else begin
        ptr_q <= ptr_q + PTR_W'(1);
      end
    end
  end
endmodule

// File: rtl/auto_commit_pkt_fifo.sv
module auto_commit_pkt_fifo
  import pfifo_pkg::*;
#(
  parameter int NUM_BUF   = 4,
  parameter int BUF_DEPTH = 512,
  parameter int DATA_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [7:0]        len_hi_i,
  input  logic [7:0]        len_lo_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  output logic              overflow_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  input  logic              rd_ready_i
);
  localparam int BUF_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam int PTR_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam int OCC_W = $clog2(NUM_BUF + 1);

  logic [LEN_W-1:0] eff_len;
  logic             we, commit, release_pkt, last;
  logic [BUF_W-1:0] wr_buf, rd_buf;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] commit_len, head_len;
  logic [OCC_W-1:0] occ_q;
  logic [CNT_W-1:0] pkt_len_q [NUM_BUF];

  // occupancy counts whole committed buffers only
  always_comb begin
    full_o     = (occ_q == OCC_W'(NUM_BUF));
    rd_valid_o = (occ_q != '0);
    rd_last_o  = last;
    head_len   = pkt_len_q[rd_buf];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   occ_q <= '0;
    else if (flush_i)              occ_q <= '0;
    else if (commit && !release_pkt) occ_q <= occ_q + OCC_W'(1);
    else if (!commit && release_pkt) occ_q <= occ_q - OCC_W'(1);
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_len
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 pkt_len_q[g] <= '0;
      else if (commit && wr_buf == BUF_W'(g))      pkt_len_q[g] <= commit_len;
    end
  end

  pfifo_len_cfg #(.BUF_DEPTH(BUF_DEPTH)) u_len (
    .len_hi_i  (len_hi_i),
    .len_lo_i  (len_lo_i),
    .eff_len_o (eff_len)
  );

  pfifo_wr_ctrl #(.NUM_BUF(NUM_BUF), .BUF_DEPTH(BUF_DEPTH)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .wr_en_i      (wr_en_i),
    .full_i       (full_o),
    .eff_len_i    (eff_len),
    .we_o         (we),
    .wr_buf_o     (wr_buf),
    .wr_ptr_o     (wr_ptr),
    .commit_o     (commit),
    .commit_len_o (commit_len),
    .overflow_o   (overflow_o)
  );

  pfifo_rd_ctrl #(.NUM_BUF(NUM_BUF), .BUF_DEPTH(BUF_DEPTH)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .avail_i    (rd_valid_o),
    .rd_ready_i (rd_ready_i),
    .head_len_i (head_len),
    .rd_buf_o   (rd_buf),
    .rd_ptr_o   (rd_ptr),
    .last_o     (last),
    .release_o  (release_pkt)
  );

  pfifo_bank #(.NUM_BUF(NUM_BUF), .BUF_DEPTH(BUF_DEPTH), .DATA_W(DATA_W)) u_bank (
    .clk_i     (clk_i),
    .we_i      (we),
    .wr_buf_i  (wr_buf),
    .wr_ptr_i  (wr_ptr),
    .wr_data_i (wr_data_i),
    .rd_buf_i  (rd_buf),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (rd_data)
  );

  logic [DATA_W-1:0] rd_data;
  always_comb rd_data_o = rd_data;
endmodule

// File: rtl/pfifo_chk.sv
module pfifo_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              wr_en_i,
  input logic              full_o,
  input logic              overflow_o,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_last_o,
  input logic              rd_ready_i
);
  a_r1_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !rd_valid_o && !full_o && !overflow_o);

  a_r5_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);

  a_r6_full_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> rd_valid_o);

  a_r6_full_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && rd_ready_i && rd_last_o && !flush_i |=> !full_o);

  a_r7_drop_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && full_o && !flush_i |=> overflow_o);

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !flush_i |=> overflow_o);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i && !flush_i |=>
      rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o));
endmodule

bind auto_commit_pkt_fifo pfifo_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_auto_commit_pkt_fifo.sv
module sim_auto_commit_pkt_fifo;
  localparam int NB = 4;
  localparam int DEPTH = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       flush_i = 1'b0;
  logic [7:0] len_hi_i = 8'h00;
  logic [7:0] len_lo_i = 8'h00;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       rd_ready_i = 1'b0;
  logic       full_o, overflow_o, rd_valid_o, rd_last_o;
  logic [7:0] rd_data_o;

  always #4 clk_i = ~clk_i;

  auto_commit_pkt_fifo #(.NUM_BUF(NB), .BUF_DEPTH(DEPTH), .DATA_W(8)) u0 (
    .clk_i, .rst_ni, .flush_i, .len_hi_i, .len_lo_i, .wr_en_i, .wr_data_i,
    .full_o, .overflow_o, .rd_valid_o, .rd_data_o, .rd_last_o, .rd_ready_i
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state built from the requirements
  logic [7:0] mbuf [NB][DEPTH];
  int  mlen [NB];
  int  mc, mf, wb, rb, rp;
  bit  mov;
  bit  hold_prev;
  logic [7:0] prev_data;
  bit  prev_last;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int req);
    if (req == 0 || req > DEPTH) return DEPTH;
    return req;
  endfunction

  function automatic void model_clear();
    mc = 0; mf = 0; wb = 0; rb = 0; rp = 0; mov = 1'b0;
  endfunction

  // one cycle: check outputs at negedge, drive, advance model over the edge
  task automatic cyc(input bit we, input logic [7:0] d, input bit rdy, input bit fl);
    bit rel, com;
    chk("R6 full", full_o, int'(mc == NB));
    chk("R7 overflow", overflow_o, int'(mov));
    chk("R3 valid", rd_valid_o, int'(mc > 0));
    if (mc > 0) begin
      chk("R4 data", rd_data_o, mbuf[rb][rp]);
      chk("R5 last", rd_last_o, int'(rp == mlen[rb] - 1));
    end
    if (hold_prev) begin
      chk("R8 hold data", rd_data_o, prev_data);
      chk("R8 hold last", rd_last_o, prev_last);
    end
    hold_prev = rd_valid_o && !rdy && !fl;
    prev_data = rd_data_o;
    prev_last = rd_last_o;
    wr_en_i = we; wr_data_i = d; rd_ready_i = rdy; flush_i = fl;
    @(posedge clk_i);
    if (fl) model_clear();
    else begin
      rel = 1'b0; com = 1'b0;
      if (we && mc == NB) mov = 1'b1;
      if (mc > 0 && rdy) begin
        if (rp == mlen[rb] - 1) begin rel = 1'b1; rp = 0; rb = (rb + 1) % NB; end
        else rp++;
      end
      if (we && mc != NB) begin
        mbuf[wb][mf] = d;
        mf++;
        if (mf >= eff_len({len_hi_i, len_lo_i})) begin
          mlen[wb] = mf; wb = (wb + 1) % NB; mf = 0; com = 1'b1;
        end
      end
      mc = mc + int'(com) - int'(rel);
    end
    @(negedge clk_i);
  endtask

  task automatic drain();
    while (mc > 0) cyc(1'b0, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic set_len(input logic [7:0] hi, input logic [7:0] lo);
    len_hi_i = hi; len_lo_i = lo;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    hold_prev = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", rd_valid_o, 0);
    chk("R1 reset full", full_o, 0);
    chk("R1 reset overflow", overflow_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: zero length clamps to depth
    set_len(8'h00, 8'h00);
    for (int i = 0; i < DEPTH - 1; i++) cyc(1'b1, 8'(i + 1), 1'b0, 1'b0);
    chk("R2 zero len no commit early", rd_valid_o, 0);
    cyc(1'b1, 8'hA5, 1'b0, 1'b0);
    chk("R2 zero len commit at depth", rd_valid_o, 1);
    drain();

    // R2: 0x0200 exceeds depth, clamps
    set_len(8'h02, 8'h00);
    for (int i = 0; i < DEPTH - 1; i++) cyc(1'b1, 8'(i + 40), 1'b0, 1'b0);
    chk("R2 oversize no commit early", rd_valid_o, 0);
    cyc(1'b1, 8'h3C, 1'b0, 1'b0);
    chk("R2 oversize commit at depth", rd_valid_o, 1);
    drain();

    // R3: short packet commits exactly at length
    set_len(8'h00, 8'h05);
    for (int i = 0; i < 4; i++) cyc(1'b1, 8'(i + 100), 1'b0, 1'b0);
    chk("R3 four of five no commit", rd_valid_o, 0);
    cyc(1'b1, 8'h77, 1'b0, 1'b0);
    chk("R3 commit at five", rd_valid_o, 1);
    drain();

    // R6/R7: fill every buffer, then write while full
    set_len(8'h00, 8'h03);
    for (int i = 0; i < 3 * NB; i++) cyc(1'b1, 8'(i + 200), 1'b0, 1'b0);
    chk("R6 full after all buffers", full_o, 1);
    chk("R7 no overflow yet", overflow_o, 0);
    cyc(1'b1, 8'hEE, 1'b0, 1'b0);
    chk("R7 overflow after dropped write", overflow_o, 1);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R6 still full before last byte", full_o, 1);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R6 full clears after packet read", full_o, 0);
    drain();
    chk("R7 overflow sticky after drain", overflow_o, 1);

    // R1: flush
    cyc(1'b1, 8'h11, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R1 flush overflow", overflow_o, 0);
    chk("R1 flush valid", rd_valid_o, 0);
    cyc(1'b1, 8'h21, 1'b0, 1'b0);
    cyc(1'b1, 8'h22, 1'b0, 1'b0);
    chk("R1 flush restarts fill count", rd_valid_o, 0);
    cyc(1'b1, 8'h23, 1'b0, 1'b0);
    chk("R1 flush fresh packet commits", rd_valid_o, 1);
    drain();

    // R9: length lowered mid-packet
    set_len(8'h00, 8'h08);
    for (int i = 0; i < 5; i++) cyc(1'b1, 8'(i + 60), 1'b0, 1'b0);
    set_len(8'h00, 8'h03);
    chk("R9 no commit before next write", rd_valid_o, 0);
    cyc(1'b1, 8'h99, 1'b0, 1'b0);
    chk("R9 commit on next write", rd_valid_o, 1);
    drain();

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      bit we, rdy, fl;
      int r;
      if ($urandom % 60 == 0) begin
        r = $urandom % 24;
        if (r >= 21) set_len(8'h02, 8'h00);
        else set_len(8'h00, 8'(r));
      end
      we  = ($urandom % 4) != 0;
      rdy = (i < 3000) ? (($urandom % 4) == 0) : (($urandom % 4) != 0);
      fl  = ($urandom % 500) == 0;
      cyc(we, 8'($urandom), rdy, fl);
    end
    drain();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule